// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit operand by an amount that comes from a register rather than from the instruction encoding. Only the least significant byte of that register counts. Four operations are supported: logical left, logical right, arithmetic right and rotate right. Alongside the shifted value the block produces the shifter carry-out, which is the last bit shifted out of the operand. The amount byte can reach 255, so the block applies separate result and carry rules when the amount is zero, exactly the word width, or larger than the word width. Rotation wraps the amount modulo 32.

The shifter sits in the operand path of an execute stage. Each cycle it takes the operand, the amount register, the operation code and the present carry flag. It presents the result and the new carry one clock later from registered outputs. A synchronous active-high reset clears those outputs.

Top module: `regshift_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` and `carry_o` become 0 after that edge.
- R2: Bits 31:8 of `amt_reg_i` have no effect on either output. Only bits 7:0 set the amount n (0 to 255).
- R3: When n = 0, for every operation, `result_o` equals the operand and `carry_o` equals `carry_i`.
- R4: `kind_i` selects the operation: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R5: Logical left with n from 1 to 31 gives the operand shifted left by n with zero fill, and carry = operand bit (32 - n).
- R6: Logical left with n = 32 gives result 0 and carry = operand bit 0. With n > 32 both the result and the carry are 0.
- R7: Logical right with n from 1 to 31 gives the operand shifted right by n with zero fill, and carry = operand bit (n - 1).
- R8: Logical right with n = 32 gives result 0 and carry = operand bit 31. With n > 32 both the result and the carry are 0.
- R9: Arithmetic right with n from 1 to 31 fills with the sign bit, and carry = operand bit (n - 1). With n >= 32 every result bit equals operand bit 31, and carry = operand bit 31.
- R10: Rotate right uses r = n mod 32. When r = 0 and n != 0, the result is the operand unchanged and carry = operand bit 31. Otherwise the result is the operand rotated right by r, and carry = operand bit (r - 1).
- R11: The outputs reflect the inputs sampled at a rising edge and hold until the next rising edge. The latency is exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_i | input | 32 | Operand to shift or rotate |
| amt_reg_i | input | 32 | Register holding the shift amount in bits 7:0 |
| kind_i | input | 2 | Operation select |
| carry_i | input | 1 | Present carry flag |
| result_o | output | 32 | Registered shifted or rotated value |
| carry_o | output | 1 | Registered carry-out flag |

## Verification
The result and the carry both come from one register stage. Each is due right after the rising edge that samples its inputs. The bench drives a vector on the falling edge and reads both outputs 1 ns after the next rising edge. It also confirms once that the outputs still show the previous vector before that edge. The sweep covers every operation, all 256 amount values, both carry inputs and eight operand patterns. The upper amount bits vary with each vector, which exercises R2 on every check.

// File: rtl/regshift_pkg.sv
package regshift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/regshift_amt_decode.sv
module regshift_amt_decode #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic             is_zero_o,
  output logic             is_full_o,
  output logic             is_over_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  assign is_zero_o = (amt_i == '0);
  assign is_full_o = (amt_i == FULL);
  assign is_over_o = (amt_i > FULL);
  assign idx_o     = amt_i[IDX_W-1:0];
endmodule

// File: rtl/regshift_rotor.sv
module regshift_rotor
  import regshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] res_o
);
  logic go_left, wrap, fill;
  logic [DATA_W-1:0] pre, post;
  logic [DATA_W-1:0] stg [IDX_W+1];

  assign go_left = (kind_i == SK_LSL);
  assign wrap    = (kind_i == SK_ROR);
  assign fill    = (kind_i == SK_ASR) & opnd_i[DATA_W-1];

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign pre[b]  = go_left ? opnd_i[DATA_W-1-b] : opnd_i[b];
    assign res_o[b] = go_left ? post[DATA_W-1-b] : post[b];
  end

  assign stg[0] = pre;

  for (genvar s = 0; s < IDX_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [SH-1:0] top_bits;
    assign top_bits = wrap ? stg[s][SH-1:0] : {SH{fill}};
    assign stg[s+1] = idx_i[s] ? {top_bits, stg[s][DATA_W-1:SH]} : stg[s];
  end

  assign post = stg[IDX_W];
endmodule

// File: rtl/regshift_carry.sv
module regshift_carry
  import regshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              is_zero_i,
  input  logic              is_full_i,
  input  logic              is_over_i,
  input  shift_kind_e       kind_i,
  input  logic              carry_i,
  output logic              carry_o
);
  logic [IDX_W-1:0] left_pos, right_pos;

  assign left_pos  = IDX_W'(0) - idx_i;
  assign right_pos = idx_i - IDX_W'(1);

  always_comb begin
    carry_o = carry_i;
    if (!is_zero_i) begin
      unique case (kind_i)
        SK_LSL: begin
          if (is_over_i)      carry_o = 1'b0;
          else if (is_full_i) carry_o = opnd_i[0];
          else                carry_o = opnd_i[left_pos];
        end
        SK_LSR: begin
          if (is_over_i)      carry_o = 1'b0;
          else if (is_full_i) carry_o = opnd_i[DATA_W-1];
          else                carry_o = opnd_i[right_pos];
        end
        SK_ASR: begin
          if (is_over_i || is_full_i) carry_o = opnd_i[DATA_W-1];
          else                        carry_o = opnd_i[right_pos];
        end
        default: carry_o = opnd_i[right_pos];
      endcase
    end
  end
endmodule

// File: rtl/regshift_unit.sv
module regshift_unit
  import regshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic [1:0]        kind_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt;
  logic              is_zero, is_full, is_over;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] core_res, res_n;
  logic              carry_n;
  logic              unused_hi;

  assign kind      = shift_kind_e'(kind_i);
  assign amt       = amt_reg_i[AMT_W-1:0];
  assign unused_hi = ^amt_reg_i[DATA_W-1:AMT_W];

  regshift_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .amt_i(amt), .is_zero_o(is_zero), .is_full_o(is_full),
    .is_over_o(is_over), .idx_o(idx)
  );

  regshift_rotor #(.DATA_W(DATA_W)) u_rot (
    .opnd_i(opnd_i), .idx_i(idx), .kind_i(kind), .res_o(core_res)
  );

  regshift_carry #(.DATA_W(DATA_W)) u_cy (
    .opnd_i(opnd_i), .idx_i(idx), .is_zero_i(is_zero), .is_full_i(is_full),
    .is_over_i(is_over), .kind_i(kind), .carry_i(carry_i), .carry_o(carry_n)
  );

  always_comb begin
    res_n = core_res;
    if (is_zero) begin
      res_n = opnd_i;
    end else if (is_full || is_over) begin
      unique case (kind)
        SK_LSL, SK_LSR: res_n = '0;
        SK_ASR:         res_n = {DATA_W{opnd_i[DATA_W-1]}};
        default:        res_n = core_res;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      result_o <= res_n;
      carry_o  <= carry_n;
    end
  end

  // R1: reset clears the registered outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && carry_o == 1'b0));

  // R3: zero amount passes operand and carry through
  assert_zero_amount_R3: assert property (@(posedge clk) disable iff (rst)
    (amt == '0) |=> (result_o == $past(opnd_i) && carry_o == $past(carry_i)));

  // R6: logical left past the width clears both outputs
  assert_lsl_over_R6: assert property (@(posedge clk) disable iff (rst)
    (kind == SK_LSL && amt > AMT_W'(DATA_W)) |=> (result_o == '0 && !carry_o));

  // R8: logical right past the width clears both outputs
  assert_lsr_over_R8: assert property (@(posedge clk) disable iff (rst)
    (kind == SK_LSR && amt > AMT_W'(DATA_W)) |=> (result_o == '0 && !carry_o));

  // R9: arithmetic right at or past the width replicates the sign
  assert_asr_sign_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (kind == SK_ASR && amt >= AMT_W'(DATA_W)) |=>
      ($countones(result_o) == (result_o[DATA_W-1] ? DATA_W : 0) &&
       carry_o == result_o[DATA_W-1] && carry_o == $past(opnd_i[DATA_W-1])));

  // R10: rotate by a non-zero multiple of the width keeps the operand
  assert_ror_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (kind == SK_ROR && amt != '0 && amt[IDX_W-1:0] == '0) |=>
      (result_o == $past(opnd_i) && carry_o == $past(opnd_i[DATA_W-1])));
endmodule

// File: tb/regshift_unit_bench.sv
module regshift_unit_bench;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] opnd_i = '0;
  logic [DATA_W-1:0] amt_reg_i = '0;
  logic [1:0]        kind_i = 2'b00;
  logic              carry_i = 1'b0;
  logic [DATA_W-1:0] result_o;
  logic              carry_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  regshift_unit u_regshift_unit (
    .clk(clk), .rst(rst), .opnd_i(opnd_i), .amt_reg_i(amt_reg_i),
    .kind_i(kind_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  function automatic logic [32:0] model(input logic [31:0] op, input int n,
                                        input logic [1:0] k, input logic cin);
    logic [31:0] r;
    logic c;
    int rr;
    r = op; c = cin;
    if (n != 0) begin
      case (k)
        2'b00: if (n < 32) begin r = op << n; c = op[32-n]; end
               else if (n == 32) begin r = '0; c = op[0]; end
               else begin r = '0; c = 1'b0; end
        2'b01: if (n < 32) begin r = op >> n; c = op[n-1]; end
               else if (n == 32) begin r = '0; c = op[31]; end
               else begin r = '0; c = 1'b0; end
        2'b10: if (n < 32) begin r = 32'($signed(op) >>> n); c = op[n-1]; end
               else begin r = {32{op[31]}}; c = op[31]; end
        default: begin
          rr = n % 32;
          if (rr == 0) begin r = op; c = op[31]; end
          else begin r = (op >> rr) | (op << (32 - rr)); c = op[rr-1]; end
        end
      endcase
    end
    return {c, r};
  endfunction

  function automatic string tag_of(input int n, input logic [1:0] k);
    if (n == 0) return "R3";
    case (k)
      2'b00: return (n < 32) ? "R5" : "R6";
      2'b01: return (n < 32) ? "R7" : "R8";
      2'b10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    checks++;
    if (result_o !== er || carry_o !== ec) begin
      fails++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, result_o, carry_o, er, ec);
    end
  endtask

  initial begin
    logic [32:0] exp;
    logic [31:0] pats [8];
    logic [31:0] lfsr;
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5A5_3C0F; pats[3] = 32'h0000_0000;
    pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h0000_0001;
    pats[6] = 32'h8000_0000; pats[7] = 32'h1234_5678;
    lfsr = 32'hACE1_2468;

    // R1: reset with busy inputs
    @(negedge clk);
    opnd_i = 32'hFFFF_FFFF; amt_reg_i = 32'h0000_0004; kind_i = 2'b11; carry_i = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R1", 32'h0, 1'b0);

    // R11: one-cycle latency and hold until next edge
    @(negedge clk);
    rst = 1'b0;
    opnd_i = 32'h0000_00F0; amt_reg_i = 32'h0000_0004; kind_i = 2'b01; carry_i = 1'b0;
    @(posedge clk); #1;
    check("R11", 32'h0000_000F, 1'b0);
    @(negedge clk);
    kind_i = 2'b00;
    #1 check("R11", 32'h0000_000F, 1'b0);
    @(posedge clk); #1;
    check("R11", 32'h0000_0F00, 1'b0);

    // R4 and R2: sweep of operation, amount, carry and operand; upper amount bits vary
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 256; n++) begin
        for (int p = 0; p < 8; p++) begin
          for (int ci = 0; ci < 2; ci++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            opnd_i    = (p == 7) ? lfsr : pats[p];
            amt_reg_i = {lfsr[23:0] ^ 24'h5A_C3E1, 8'(n)};
            kind_i    = 2'(k);
            carry_i   = 1'(ci);
            exp = model(opnd_i, n, 2'(k), 1'(ci));
            @(posedge clk); #1;
            check(tag_of(n, 2'(k)), exp[31:0], exp[32]);
          end
        end
      end
    end

    // R2: same low byte, different upper bits
    @(negedge clk);
    opnd_i = 32'hC000_0003; amt_reg_i = 32'hFFFF_FF02; kind_i = 2'b11; carry_i = 1'b0;
    @(posedge clk); #1;
    check("R2", 32'hF000_0000, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule